// File: doc/BRIEF.md
# Programmed-I/O Sector Read Engine

This block is the byte-at-a-time transfer path a disk controller uses when a sector read runs without a DMA channel. A start pulse captures the drive, the starting cylinder, head and sector, the end-of-track sector, the number of heads and the sectors per track. The engine then asks for a sector: it raises a load request and presents the linear sector address, plus the modelled load time in microsecond ticks (one revolution at 300 rpm, split by the sectors per track). An external source writes the 512 sector bytes into the engine's buffer and pulses a load-done strobe.

Once a sector is in the buffer, the status bits show that data can be read toward the host. Each host read strobe returns the next buffered byte. After the last byte of a sector, the engine steps to the next sector, or wraps to sector 1 on the next head, and requests a new load. When the last byte of the last sector on the last head is read, the engine emits a one-cycle terminal count, fills the first status byte and enters the result phase.

Top module: `pio_sector_reader`

## Requirements
- R1: After reset, the engine is idle. Ready, direction, busy, load request, terminal count and result phase are all low, and the read data, status byte 0 and load ticks are 0.
- R2: After a start pulse accepted in the idle or result phase, busy and load request are high and ready is low. After load-done, on the next edge, busy falls and ready and direction rise.
- R3: A read strobe while ready is high in the transfer phase puts the buffer byte at the current index on the read data output one cycle later, and advances the index. Byte 0 of each sector is returned first.
- R4: A read strobe while ready is low (idle or loading) changes neither the read data nor the index. The same holds in the result phase.
- R5: Terminal count is a one-cycle pulse. It is raised together with the last byte exactly when the index reaches 512, the sector equals end-of-track and the head equals the head count minus 1, and at no other time.
- R6: When the index reaches 512 without terminal count, the index returns to 0, the sector number advances and the load request rises again.
- R7: When the sector to advance is equal to end-of-track, the sector wraps to 1 and the head advances by one.
- R8: While the load request is high, the load address equals (cylinder × heads + head) × sectors_per_track + (sector − 1).
- R9: The load ticks output equals 200000 divided by the captured sectors per track, rounded down, and equals 0 when that value is 0.
- R10: On terminal count, status byte 0 becomes head in bit 2 and drive in bits 1:0, and status bytes 1 and 2 are 0. The result phase then shows ready, direction and busy all high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read using the geometry inputs |
| drive_sel | input | 2 | Drive number |
| start_cyl | input | 8 | Cylinder |
| start_head | input | 1 | First head |
| start_sector | input | 8 | First sector (1-based) |
| end_sector | input | 8 | End-of-track sector |
| head_count | input | 2 | Number of heads (1 or 2) |
| sectors_per_track | input | 8 | Sectors on one track |
| load_req | output | 1 | Sector load wanted |
| load_addr | output | 20 | Linear sector address of the wanted sector |
| load_ticks | output | 18 | Modelled load time in microsecond ticks |
| fill_we | input | 1 | Buffer write enable from the sector source |
| fill_addr | input | 9 | Buffer byte address |
| fill_data | input | 8 | Buffer byte |
| load_done | input | 1 | Sector fully written into the buffer |
| rd_strobe | input | 1 | Host data-port read |
| rd_data | output | 8 | Byte returned to the host |
| stat_ready | output | 1 | Data register ready |
| stat_dir | output | 1 | Direction: controller to host |
| stat_busy | output | 1 | Controller busy |
| term_count | output | 1 | Final byte of the transfer |
| result_active | output | 1 | Result phase |
| st0 | output | 8 | Status byte 0 |
| st1 | output | 8 | Status byte 1 |
| st2 | output | 8 | Status byte 2 |

## Verification
Some properties are checked on every cycle. Terminal count is a single-cycle pulse, it follows a read, and it comes with entry to the result phase. Read data stays frozen whenever ready is low. The index never reaches the sector size. Each sector advance either increments the sector or wraps it to 1. The load address holds steady for the whole of a load request. Other behaviour can only be shown by the bench's runs: the byte order across sector and head boundaries, the address sequence, terminal count landing on exactly the final byte of a two-head transfer and of a one-head transfer, and the status byte contents.

// File: rtl/pio_rd_pkg.sv
package pio_rd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOAD   = 2'd1,
    PH_XFER   = 2'd2,
    PH_RESULT = 2'd3
  } phase_t;
endpackage

// File: rtl/pio_sector_buf.sv
module pio_sector_buf #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pio_geom_track.sv
module pio_geom_track #(
  parameter int SEC_W     = 8,
  parameter int CYL_W     = 8,
  parameter int HCNT_W    = 2,
  parameter int LBA_W     = 20,
  parameter int TICK_W    = 18,
  parameter int REV_TICKS = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [CYL_W-1:0]  cyl_in,
  input  logic              head_in,
  input  logic [SEC_W-1:0]  sector_in,
  input  logic [SEC_W-1:0]  eot_in,
  input  logic [HCNT_W-1:0] heads_in,
  input  logic [SEC_W-1:0]  spt_in,
  output logic              head_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic              last_o
);
  logic [CYL_W-1:0]  cyl_q, cyl_d;
  logic [SEC_W-1:0]  eot_q, eot_d, spt_q, spt_d, sec_q, sec_d;
  logic [HCNT_W-1:0] heads_q, heads_d;
  logic              head_q, head_d;
  logic [LBA_W-1:0]  track_w;

  always_comb begin
    cyl_d   = cyl_q;
    eot_d   = eot_q;
    spt_d   = spt_q;
    heads_d = heads_q;
    sec_d   = sec_q;
    head_d  = head_q;
    if (load) begin
      cyl_d   = cyl_in;
      eot_d   = eot_in;
      spt_d   = spt_in;
      heads_d = heads_in;
      sec_d   = sector_in;
      head_d  = head_in;
    end else if (advance) begin
      if (sec_q == eot_q) begin
        sec_d  = SEC_W'(1);
        head_d = head_q + 1'b1;
      end else begin
        sec_d  = sec_q + SEC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyl_q   <= '0;
      eot_q   <= '0;
      spt_q   <= '0;
      heads_q <= '0;
      sec_q   <= '0;
      head_q  <= 1'b0;
    end else begin
      cyl_q   <= cyl_d;
      eot_q   <= eot_d;
      spt_q   <= spt_d;
      heads_q <= heads_d;
      sec_q   <= sec_d;
      head_q  <= head_d;
    end
  end

  assign track_w = LBA_W'(cyl_q) * LBA_W'(heads_q) + LBA_W'(head_q);
  assign lba_o   = track_w * LBA_W'(spt_q) + LBA_W'(sec_q) - LBA_W'(1);
  assign ticks_o = (spt_q == '0) ? '0 : TICK_W'(REV_TICKS / int'(spt_q));
  assign last_o  = (sec_q == eot_q) &&
                   ({{(HCNT_W-1){1'b0}}, head_q} == heads_q - HCNT_W'(1));
  assign head_o  = head_q;

  // R7: an advance either wraps the sector to 1 or adds one to it
  assert_sector_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (sec_q == SEC_W'(1)) || (sec_q == $past(sec_q) + SEC_W'(1)));
endmodule

// File: rtl/pio_sector_reader.sv
module pio_sector_reader
  import pio_rd_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int SEC_W        = 8,
  parameter int CYL_W        = 8,
  parameter int HCNT_W       = 2,
  parameter int DRV_W        = 2,
  parameter int LBA_W        = 20,
  parameter int TICK_W       = 18,
  parameter int REV_TICKS    = 200000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start,
  input  logic [DRV_W-1:0]                drive_sel,
  input  logic [CYL_W-1:0]                start_cyl,
  input  logic                            start_head,
  input  logic [SEC_W-1:0]                start_sector,
  input  logic [SEC_W-1:0]                end_sector,
  input  logic [HCNT_W-1:0]               head_count,
  input  logic [SEC_W-1:0]                sectors_per_track,
  output logic                            load_req,
  output logic [LBA_W-1:0]                load_addr,
  output logic [TICK_W-1:0]               load_ticks,
  input  logic                            fill_we,
  input  logic [$clog2(SECTOR_BYTES)-1:0] fill_addr,
  input  logic [DATA_W-1:0]               fill_data,
  input  logic                            load_done,
  input  logic                            rd_strobe,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            stat_ready,
  output logic                            stat_dir,
  output logic                            stat_busy,
  output logic                            term_count,
  output logic                            result_active,
  output logic [7:0]                      st0,
  output logic [7:0]                      st1,
  output logic [7:0]                      st2
);
  localparam int ADDR_W = $clog2(SECTOR_BYTES);
  localparam int IDX_W  = $clog2(SECTOR_BYTES + 1);

  phase_t            phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_inc;
  logic [DATA_W-1:0] rdat_q, rdat_d, buf_byte;
  logic              tc_q, tc_d;
  logic [7:0]        st0_q, st0_d;
  logic [DRV_W-1:0]  drv_q, drv_d;
  logic              geo_load, geo_adv, geo_last, geo_head;

  pio_sector_buf #(.DEPTH(SECTOR_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .wr_en   (fill_we),
    .wr_addr (fill_addr),
    .wr_data (fill_data),
    .rd_addr (idx_q[ADDR_W-1:0]),
    .rd_data (buf_byte)
  );

  pio_geom_track #(
    .SEC_W(SEC_W), .CYL_W(CYL_W), .HCNT_W(HCNT_W), .LBA_W(LBA_W),
    .TICK_W(TICK_W), .REV_TICKS(REV_TICKS)
  ) u_geom (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (geo_load),
    .advance   (geo_adv),
    .cyl_in    (start_cyl),
    .head_in   (start_head),
    .sector_in (start_sector),
    .eot_in    (end_sector),
    .heads_in  (head_count),
    .spt_in    (sectors_per_track),
    .head_o    (geo_head),
    .lba_o     (load_addr),
    .ticks_o   (load_ticks),
    .last_o    (geo_last)
  );

  assign idx_inc = idx_q + IDX_W'(1);

  always_comb begin
    phase_d  = phase_q;
    idx_d    = idx_q;
    rdat_d   = rdat_q;
    tc_d     = 1'b0;
    st0_d    = st0_q;
    drv_d    = drv_q;
    geo_load = 1'b0;
    geo_adv  = 1'b0;
    case (phase_q)
      PH_IDLE, PH_RESULT: begin
        if (start) begin
          phase_d  = PH_LOAD;
          idx_d    = '0;
          drv_d    = drive_sel;
          geo_load = 1'b1;
        end
      end
      PH_LOAD: begin
        if (load_done) begin
          phase_d = PH_XFER;
          idx_d   = '0;
        end
      end
      PH_XFER: begin
        if (rd_strobe) begin
          rdat_d = buf_byte;
          idx_d  = idx_inc;
          if (idx_inc == IDX_W'(SECTOR_BYTES)) begin
            idx_d = '0;
            if (geo_last) begin
              tc_d    = 1'b1;
              st0_d   = 8'({geo_head, 2'b00} | 3'(drv_q));
              phase_d = PH_RESULT;
            end else begin
              geo_adv = 1'b1;
              phase_d = PH_LOAD;
            end
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      rdat_q  <= '0;
      tc_q    <= 1'b0;
      st0_q   <= '0;
      drv_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      rdat_q  <= rdat_d;
      tc_q    <= tc_d;
      st0_q   <= st0_d;
      drv_q   <= drv_d;
    end
  end

  assign load_req      = (phase_q == PH_LOAD);
  assign stat_ready    = (phase_q == PH_XFER) || (phase_q == PH_RESULT);
  assign stat_dir      = stat_ready;
  assign stat_busy     = (phase_q == PH_LOAD) || (phase_q == PH_RESULT);
  assign result_active = (phase_q == PH_RESULT);
  assign term_count    = tc_q;
  assign rd_data       = rdat_q;
  assign st0           = st0_q;
  assign st1           = 8'h00;
  assign st2           = 8'h00;

  // R2: no ready until the source has reported the sector loaded
  assert_wait_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !load_done) |=> !stat_ready);
  // R4: read data frozen while ready is low
  assert_hold_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_ready |=> $stable(rd_data));
  // R5: terminal count lasts one cycle
  assert_tc_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term_count |=> !term_count);
  // R5: terminal count follows a host read and lands in the result phase
  assert_tc_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    term_count |-> ($past(rd_strobe) && result_active));
  // R3: the byte index stays inside the sector
  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(SECTOR_BYTES));
  // R8: address held for the whole load request
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && $past(load_req)) |-> $stable(load_addr));
endmodule

// File: tb/pio_sector_reader_tb.sv
module pio_sector_reader_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start, fill_we, load_done, rd_strobe;
  logic [1:0]  drive_sel, head_count;
  logic [7:0]  start_cyl, start_sector, end_sector, sectors_per_track;
  logic        start_head;
  logic [8:0]  fill_addr;
  logic [7:0]  fill_data, rd_data, st0, st1, st2;
  logic        load_req, stat_ready, stat_dir, stat_busy, term_count, result_active;
  logic [19:0] load_addr;
  logic [17:0] load_ticks;

  int n_cmp = 0, n_bad = 0, cyc = 0, tc_seen = 0, loads = 0;
  bit rd_en = 0, done = 0;

  // reference model state
  int m_ph, m_idx, m_rd, m_tc, m_st0, m_drv, m_cyl, m_head, m_sec, m_eot, m_heads, m_spt;

  pio_sector_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .drive_sel(drive_sel),
    .start_cyl(start_cyl), .start_head(start_head), .start_sector(start_sector),
    .end_sector(end_sector), .head_count(head_count),
    .sectors_per_track(sectors_per_track), .load_req(load_req),
    .load_addr(load_addr), .load_ticks(load_ticks), .fill_we(fill_we),
    .fill_addr(fill_addr), .fill_data(fill_data), .load_done(load_done),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .stat_ready(stat_ready),
    .stat_dir(stat_dir), .stat_busy(stat_busy), .term_count(term_count),
    .result_active(result_active), .st0(st0), .st1(st1), .st2(st2)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pat(int lba, int i);
    return (lba * 29 + i + (i >> 8) * 101) & 255;
  endfunction

  function automatic int m_lba();
    return ((m_cyl * m_heads + m_head) * m_spt + m_sec - 1) & 20'hFFFFF;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // reference model, advanced on every clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_idx = 0; m_rd = 0; m_tc = 0; m_st0 = 0; m_drv = 0;
      m_cyl = 0; m_head = 0; m_sec = 0; m_eot = 0; m_heads = 0; m_spt = 0;
    end else begin
      cyc++;
      m_tc = 0;
      case (m_ph)
        0, 3: if (start) begin
          m_ph = 1; m_idx = 0; m_drv = drive_sel; m_cyl = start_cyl;
          m_head = start_head; m_sec = start_sector; m_eot = end_sector;
          m_heads = head_count; m_spt = sectors_per_track;
        end
        1: if (load_done) begin m_ph = 2; m_idx = 0; end
        2: if (rd_strobe) begin
          m_rd = pat(m_lba(), m_idx);
          m_idx++;
          if (m_idx == 512) begin
            m_idx = 0;
            if (m_sec == m_eot && m_head == m_heads - 1) begin
              m_tc = 1; m_st0 = m_head * 4 + m_drv; m_ph = 3; tc_seen++;
            end else begin
              if (m_sec == m_eot) begin m_sec = 1; m_head++; end
              else m_sec++;
              m_ph = 1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    check("R3 rd_data", rd_data, m_rd);
    check("R5 term_count", term_count, m_tc);
    check("R2 stat_ready", stat_ready, (m_ph == 2 || m_ph == 3));
    check("R2 stat_dir", stat_dir, (m_ph == 2 || m_ph == 3));
    check("R2 stat_busy", stat_busy, (m_ph == 1 || m_ph == 3));
    check("R6 load_req", load_req, (m_ph == 1));
    if (m_ph == 1) check("R8 load_addr", load_addr, m_lba());
    check("R9 load_ticks", load_ticks, (m_spt == 0) ? 0 : 200000 / m_spt);
    check("R10 result_active", result_active, (m_ph == 3));
    check("R10 st0", st0, m_st0);
    check("R10 st1", st1, 0);
    check("R10 st2", st2, 0);
  end

  // host reader: strobes two cycles of three, also while loading (R4)
  always @(negedge clk) rd_strobe <= rd_en && (cyc % 3 != 1);

  // sector source
  initial begin
    fill_we = 0; load_done = 0; fill_addr = 0; fill_data = 0;
    forever begin
      @(negedge clk);
      if (rst_n && load_req) begin
        loads++;
        for (int i = 0; i < 512; i++) begin
          fill_we = 1; fill_addr = 9'(i); fill_data = 8'(pat(m_lba(), i));
          @(negedge clk);
        end
        fill_we = 0; load_done = 1;
        @(negedge clk);
        load_done = 0;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run completion)");
    summary();
  end

  task automatic run(int drv, int cyl, int hd, int sec, int eot, int hcnt, int spt);
    @(negedge clk);
    drive_sel = 2'(drv); start_cyl = 8'(cyl); start_head = 1'(hd);
    start_sector = 8'(sec); end_sector = 8'(eot); head_count = 2'(hcnt);
    sectors_per_track = 8'(spt); start = 1;
    @(negedge clk);
    start = 0; rd_en = 1;
    while (!result_active) @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    rst_n = 0; start = 0; rd_strobe = 0;
    drive_sel = 0; start_cyl = 0; start_head = 0; start_sector = 0;
    end_sector = 0; head_count = 0; sectors_per_track = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 ready", stat_ready, 0);
    check("R1 busy", stat_busy, 0);
    check("R1 load_req", load_req, 0);
    check("R1 term_count", term_count, 0);
    check("R1 result", result_active, 0);
    check("R1 ticks", load_ticks, 0);
    check("R1 st0", st0, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // two heads, two sectors per track: addresses 12..15, head wrap (R7)
    run(1, 3, 0, 1, 2, 2, 2);
    check("R7 sectors loaded across head wrap", loads, 4);
    check("R5 single terminal count", tc_seen, 1);
    check("R10 st0 head1 drive1", st0, 5);
    // R4: reads in the result phase change nothing
    rd_en = 1; repeat (6) @(negedge clk); rd_en = 0;
    check("R4 result phase read ignored", rd_data, pat(15, 511));

    // one head, starting mid-track: addresses 10..11
    run(2, 1, 0, 2, 3, 1, 9);
    check("R6 sectors loaded one head", loads, 6);
    check("R5 second terminal count", tc_seen, 2);
    check("R10 st0 head0 drive2", st0, 2);
    check("R3 last byte", rd_data, pat(11, 511));
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule